// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers on a plain memory-mapped bus. Each register has its own chip-select line. Every access also carries a size code, and the two wide registers also use a byte offset. Writes take effect on the clock edge. Reads are combinational from the current state.

Most registers do more than store data. The auxiliary register turns a write of one bit into a single-cycle terminal-count strobe. The power-down register holds a power-off bit, which drives a shutdown request. It also holds a sticky power-fail status bit that is set by the power-fail input and cleared by a write-to-clear bit. The system-control register accepts a single command: it records a reset-status value and pulses a reset request. A power-fail interrupt is raised while the status bit is set and the configuration register enables it.

A bus reset clears the configuration, auxiliary, power-down and modem-control registers. The diagnostic, LED and system-control registers keep their contents through reset.

Top module: `aux_sysctl_bank`

## Requirements
- R1: `pf_irq` is high exactly while power-down bit 5 (power-fail status) and configuration bit 3 (interrupt enable) are both set. It follows a write to either register on the cycle after that write.
- R2: When `pf_in` differs from its value on the previous clock edge, power-down bit 5 becomes `pf_in` AND configuration bit 3, using the configuration value held before that edge. Without such a change, bit 5 keeps its value (sticky).
- R3: A valid write to the auxiliary register with data bit 1 set makes `tc_pulse` high for exactly the one cycle after the write. The register then reads back the written byte with bit 1 cleared.
- R4: A valid power-down write stores data bit 0 as the power-off bit and keeps status bit 5. Every other bit reads back 0.
- R5: A valid power-down write with data bit 1 set clears status bit 5. Bit 1 itself is never stored.
- R6: `shutdown_req` equals the stored power-off bit (power-down bit 0).
- R7: A valid system-control write with data bit 0 set loads that register with 0x02 and makes `reset_req` high for exactly the one cycle after the write. A write with bit 0 clear changes nothing.
- R8: `rst` clears the configuration, auxiliary, power-down and modem-control registers and drops all four outputs. The diagnostic, LED and system-control registers keep their values.
- R9: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = reserved. The configuration, diagnostic, modem-control, auxiliary and power-down registers take size 0, the LED register takes size 1, and the system-control register takes size 2. A write with another size is ignored, with no side effect, and a read with another size returns 0.
- R10: The LED and system-control registers respond only at offset 0. At any other offset, reads return 0 and writes are ignored. The byte registers ignore the offset.
- R11: The configuration, diagnostic and modem-control registers store and return any byte, and the LED register stores and returns any 16-bit value.
- R12: If a `pf_in` change and a power-down write fall in the same cycle, the change is evaluated first and the write applies after it. A clear bit in that write therefore wins over a simultaneous rise.
- R13: Chip-select bits are one-hot or zero: bit 0 configuration, 1 diagnostic, 2 modem control, 3 auxiliary, 4 power-down, 5 system control, 6 LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| bus_cs | input | 7 | One-hot register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_size | input | 2 | Access size code |
| bus_off | input | 2 | Byte offset within the wide registers |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero-extended |
| pf_in | input | 1 | Power-fail indication |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | One-cycle terminal-count strobe |
| shutdown_req | output | 1 | Shutdown request, level |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The contested case is a `pf_in` edge in the same cycle as a power-down write. Here the edge-driven status update and the write-to-clear logic both try to set the next value of status bit 5. The bench provokes this by moving `pf_in` and issuing the write on the same falling edge. It does this twice: once with the clear bit set, where the status must end at 0 even though the input has just risen, and once without it, where the status must take the freshly evaluated value while the power-off bit follows the data. After each case it reads the register back, checks `pf_irq` against its own model, and then confirms that the still-high input does not set the status again.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int NUM_REGS = 7;

    typedef enum logic [2:0] {
        RG_CFG   = 3'd0,
        RG_DIAG  = 3'd1,
        RG_MODEM = 3'd2,
        RG_AUX   = 3'd3,
        RG_PWR   = 3'd4,
        RG_SYS   = 3'd5,
        RG_LED   = 3'd6
    } reg_id_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int CFG_IRQ_EN_BIT = 3;
    localparam int AUX_TC_BIT     = 1;
    localparam int PWR_OFF_BIT    = 0;
    localparam int PWR_CLR_BIT    = 1;
    localparam int PWR_FAIL_BIT   = 5;
    localparam int SYS_CMD_BIT    = 0;
    localparam logic [7:0] SYS_STATUS_VAL = 8'h02;

    typedef struct packed {
        logic [NUM_REGS-1:0] wr;
        logic [NUM_REGS-1:0] rd;
    } acc_en_t;

    function automatic acc_size_e reg_width(input int idx);
        if (idx == int'(RG_SYS))      return SZ_WORD;
        else if (idx == int'(RG_LED)) return SZ_HALF;
        else                          return SZ_BYTE;
    endfunction

    function automatic bit reg_offset_checked(input int idx);
        return (idx == int'(RG_SYS)) || (idx == int'(RG_LED));
    endfunction

endpackage

// File: rtl/aux_sysctl_decode.sv
module aux_sysctl_decode
    import aux_sysctl_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int OFF_W  = 2
) (
    input  logic [N_REGS-1:0] cs,
    input  logic              wr,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    output acc_en_t           en
);

    logic [N_REGS-1:0] ok;

    for (genvar g = 0; g < N_REGS; g++) begin : g_sel
        localparam acc_size_e NEED = reg_width(g);
        localparam bit        CHK  = reg_offset_checked(g);
        assign ok[g] = cs[g] && (size == NEED) && (!CHK || (off == '0));
    end

    assign en.wr = ok & {N_REGS{wr}};
    assign en.rd = ok;

endmodule

// File: rtl/aux_sysctl_pwr.sv
module aux_sysctl_pwr
    import aux_sysctl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_in,
    input  logic              irq_en,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] pwr_q,
    output logic              irq,
    output logic              shutdown
);

    logic pf_q, fail_q, off_q;
    logic fail_eval, fail_n, off_n;

    always_comb begin
        fail_eval = (pf_in != pf_q) ? (pf_in & irq_en) : fail_q;
        fail_n    = fail_eval;
        off_n     = off_q;
        if (wr) begin
            off_n = wdata[PWR_OFF_BIT];
            if (wdata[PWR_CLR_BIT]) fail_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_q   <= 1'b0;
            fail_q <= 1'b0;
            off_q  <= 1'b0;
        end else begin
            pf_q   <= pf_in;
            fail_q <= fail_n;
            off_q  <= off_n;
        end
    end

    always_comb begin
        pwr_q               = '0;
        pwr_q[PWR_FAIL_BIT] = fail_q;
        pwr_q[PWR_OFF_BIT]  = off_q;
    end

    assign irq      = fail_q & irq_en;
    assign shutdown = off_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[PWR_CLR_BIT]) |=> !fail_q); // R5

    AST_FAIL_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_q) |-> $past(pf_in && irq_en)); // R2

    AST_OFF_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(off_q) |-> ($past(wr) || $past(rst))); // R6

    AST_IRQ_NEEDS_FAIL: assert property (@(posedge clk) disable iff (rst)
        irq |-> pwr_q[PWR_FAIL_BIT]); // R1

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int LED_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_REGS-1:0] wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [BYTE_W-1:0] diag_q,
    output logic [BYTE_W-1:0] modem_q,
    output logic [BYTE_W-1:0] aux_q,
    output logic [BYTE_W-1:0] sys_q,
    output logic [LED_W-1:0]  led_q,
    output logic              tc_q,
    output logic              rreq_q
);

    localparam logic [BYTE_W-1:0] AUX_KEEP = ~(BYTE_W'(1) << AUX_TC_BIT);

    logic [BYTE_W-1:0] wbyte;
    logic              sys_cmd;
    logic              unused_hi;

    assign wbyte     = wdata[BYTE_W-1:0];
    assign sys_cmd   = wr_en[RG_SYS] && wdata[SYS_CMD_BIT];
    assign unused_hi = ^wdata[DATA_W-1:LED_W];

    // Registers cleared by bus reset
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            modem_q <= '0;
            aux_q   <= '0;
            tc_q    <= 1'b0;
            rreq_q  <= 1'b0;
        end else begin
            if (wr_en[RG_CFG])   cfg_q   <= wbyte;
            if (wr_en[RG_MODEM]) modem_q <= wbyte;
            if (wr_en[RG_AUX])   aux_q   <= wbyte & AUX_KEEP;
            tc_q   <= wr_en[RG_AUX] && wbyte[AUX_TC_BIT];
            rreq_q <= sys_cmd;
        end
    end

    // Registers that keep their value through bus reset
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (wr_en[RG_DIAG]) diag_q <= wbyte;
            if (wr_en[RG_LED])  led_q  <= wdata[LED_W-1:0];
            if (sys_cmd)        sys_q  <= SYS_STATUS_VAL;
        end
    end

    AST_TC_SOURCE: assert property (@(posedge clk) disable iff (rst)
        tc_q |-> $past(wr_en[RG_AUX] && wdata[AUX_TC_BIT])); // R3

    AST_RREQ_STATUS: assert property (@(posedge clk) disable iff (rst)
        rreq_q |-> (sys_q == SYS_STATUS_VAL)); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en[RG_CFG]) && !$past(rst)) |-> $stable(cfg_q)); // R9

    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en[RG_SYS] && wdata[SYS_CMD_BIT]) |-> $stable(sys_q)); // R7

endmodule

// File: rtl/aux_sysctl_bank.sv
module aux_sysctl_bank
    import aux_sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int LED_W  = 16,
    parameter int OFF_W  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] bus_cs,
    input  logic                bus_wr,
    input  logic [1:0]          bus_size,
    input  logic [OFF_W-1:0]    bus_off,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                pf_in,
    output logic                pf_irq,
    output logic                tc_pulse,
    output logic                shutdown_req,
    output logic                reset_req
);

    localparam int BYTE_PAD = DATA_W - BYTE_W;
    localparam int LED_PAD  = DATA_W - LED_W;

    acc_en_t           en;
    logic [BYTE_W-1:0] cfg_q, diag_q, modem_q, aux_q, sys_q, pwr_q;
    logic [LED_W-1:0]  led_q;

    aux_sysctl_decode #(.N_REGS(NUM_REGS), .OFF_W(OFF_W)) u_decode (
        .cs   (bus_cs),
        .wr   (bus_wr),
        .size (acc_size_e'(bus_size)),
        .off  (bus_off),
        .en   (en)
    );

    aux_sysctl_regs #(
        .N_REGS(NUM_REGS), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LED_W(LED_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (en.wr),
        .wdata   (bus_wdata),
        .cfg_q   (cfg_q),
        .diag_q  (diag_q),
        .modem_q (modem_q),
        .aux_q   (aux_q),
        .sys_q   (sys_q),
        .led_q   (led_q),
        .tc_q    (tc_pulse),
        .rreq_q  (reset_req)
    );

    aux_sysctl_pwr #(.BYTE_W(BYTE_W)) u_pwr (
        .clk      (clk),
        .rst      (rst),
        .pf_in    (pf_in),
        .irq_en   (cfg_q[CFG_IRQ_EN_BIT]),
        .wr       (en.wr[RG_PWR]),
        .wdata    (bus_wdata[BYTE_W-1:0]),
        .pwr_q    (pwr_q),
        .irq      (pf_irq),
        .shutdown (shutdown_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (en.rd[RG_CFG])   bus_rdata = {{BYTE_PAD{1'b0}}, cfg_q};
        if (en.rd[RG_DIAG])  bus_rdata = {{BYTE_PAD{1'b0}}, diag_q};
        if (en.rd[RG_MODEM]) bus_rdata = {{BYTE_PAD{1'b0}}, modem_q};
        if (en.rd[RG_AUX])   bus_rdata = {{BYTE_PAD{1'b0}}, aux_q};
        if (en.rd[RG_PWR])   bus_rdata = {{BYTE_PAD{1'b0}}, pwr_q};
        if (en.rd[RG_SYS])   bus_rdata = {{BYTE_PAD{1'b0}}, sys_q};
        if (en.rd[RG_LED])   bus_rdata = {{LED_PAD{1'b0}}, led_q};
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_cs)); // R13

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_size == 2'd3) |-> (bus_rdata == '0)); // R9

    AST_SHUTDOWN_BIT: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> pwr_q[PWR_OFF_BIT]); // R6

endmodule

// File: tb/aux_sysctl_bank_tb_top.sv
module aux_sysctl_bank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_cs = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [1:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pf_in = 1'b0;
    logic        pf_irq, tc_pulse, shutdown_req, reset_req;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [7:0]  m_cfg = 0, m_diag = 0, m_modem = 0, m_aux = 0, m_sys = 0;
    logic [15:0] m_led = 0;
    logic        m_fail = 0, m_off = 0, m_pf = 0;
    bit          k_diag = 0, k_sys = 0, k_led = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_sysctl_bank dut_i (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pf_in(pf_in), .pf_irq(pf_irq),
        .tc_pulse(tc_pulse), .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit fits(input int idx, input logic [1:0] sz, input logic [1:0] off);
        int need;
        need = (idx == 5) ? 2 : (idx == 6) ? 1 : 0;
        return (sz == 2'(need)) && (idx < 5 || off == 2'd0);
    endfunction

    task automatic model_wr(input int idx, input logic [1:0] sz, input logic [1:0] off,
                            input logic [31:0] d);
        if (!fits(idx, sz, off)) return;
        case (idx)
            0: m_cfg = d[7:0];
            1: begin m_diag = d[7:0]; k_diag = 1; end
            2: m_modem = d[7:0];
            3: m_aux = d[7:0] & 8'hFD;
            4: begin m_off = d[0]; if (d[1]) m_fail = 0; end
            5: if (d[0]) begin m_sys = 8'h02; k_sys = 1; end
            6: begin m_led = d[15:0]; k_led = 1; end
            default: ;
        endcase
    endtask

    task automatic bus_write(input int idx, input logic [1:0] sz, input logic [1:0] off,
                             input logic [31:0] d, input string tag);
        logic exp_tc, exp_rr;
        exp_tc = fits(idx, sz, off) && idx == 3 && d[1];
        exp_rr = fits(idx, sz, off) && idx == 5 && d[0];
        @(negedge clk);
        bus_cs = 7'(1 << idx); bus_wr = 1; bus_size = sz; bus_off = off; bus_wdata = d;
        @(negedge clk);
        chk({31'b0, tc_pulse}, {31'b0, exp_tc}, {tag, " R3 tc_pulse"});
        chk({31'b0, reset_req}, {31'b0, exp_rr}, {tag, " R7 reset_req"});
        bus_cs = '0; bus_wr = 0; bus_size = 0; bus_off = 0; bus_wdata = '0;
        model_wr(idx, sz, off, d);
    endtask

    task automatic bus_read(input int idx, input logic [1:0] sz, input logic [1:0] off,
                            output logic [31:0] data);
        @(negedge clk);
        bus_cs = 7'(1 << idx); bus_wr = 0; bus_size = sz; bus_off = off;
        #1 data = bus_rdata;
        bus_cs = '0; bus_size = 0; bus_off = 0;
    endtask

    task automatic read_chk(input int idx, input logic [1:0] sz, input logic [1:0] off,
                            input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_read(idx, sz, off, v);
        chk(v, exp, tag);
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk);
        pf_in = v;
        @(negedge clk);
        if (v != m_pf) begin m_fail = v & m_cfg[3]; m_pf = v; end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk({31'b0, tc_pulse}, 0, {tag, " R3 tc one cycle"});
        chk({31'b0, reset_req}, 0, {tag, " R7 reset_req one cycle"});
        chk({31'b0, pf_irq}, {31'b0, m_fail & m_cfg[3]}, {tag, " R1 pf_irq"});
        chk({31'b0, shutdown_req}, {31'b0, m_off}, {tag, " R6 shutdown_req"});
        read_chk(0, 0, 0, {24'b0, m_cfg}, {tag, " R11 cfg"});
        read_chk(2, 0, 0, {24'b0, m_modem}, {tag, " R11 modem"});
        read_chk(3, 0, 0, {24'b0, m_aux}, {tag, " R3 aux"});
        read_chk(4, 0, 0, {24'b0, 2'b0, m_fail, 4'b0, m_off}, {tag, " R4 pwrdn"});
        if (k_diag) read_chk(1, 0, 0, {24'b0, m_diag}, {tag, " R11 diag"});
        if (k_sys)  read_chk(5, 2, 0, {24'b0, m_sys}, {tag, " R7 sysctl"});
        if (k_led)  read_chk(6, 1, 0, {16'b0, m_led}, {tag, " R11 led"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; pf_in = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_cfg = 0; m_aux = 0; m_modem = 0; m_fail = 0; m_off = 0; m_pf = 0;
    endtask

    task automatic t_reset_state();
        check_all("R8 reset state");
    endtask

    task automatic t_plain_rw();
        bus_write(0, 0, 0, 32'hA5, "R11");   check_all("R11 cfg A5");
        bus_write(1, 0, 3, 32'h5A, "R11");   check_all("R11 diag 5A");
        bus_write(2, 0, 0, 32'hFF, "R11");   check_all("R11 modem FF");
        bus_write(6, 1, 0, 32'hBEEF, "R11"); check_all("R11 led BEEF");
        bus_write(0, 0, 0, 32'h00, "R11");   check_all("R11 cfg 00");
    endtask

    task automatic t_aux_tc();
        bus_write(3, 0, 0, 32'hFF, "R3 aux FF"); check_all("R3 aux FF");
        bus_write(3, 0, 0, 32'h02, "R3 aux 02"); check_all("R3 aux 02");
        bus_write(3, 0, 0, 32'h01, "R3 aux 01"); check_all("R3 aux 01");
    endtask

    task automatic t_power_fail();
        bus_write(0, 0, 0, 32'h08, "R1 enable"); check_all("R1 enable");
        set_pf(1);                                 check_all("R2 pf rise enabled");
        bus_write(0, 0, 0, 32'h00, "R1 disable"); check_all("R2 sticky with enable off");
        bus_write(0, 0, 0, 32'h08, "R1 reenable"); check_all("R1 irq back");
        set_pf(0);                                 check_all("R2 pf fall");
        bus_write(0, 0, 0, 32'h00, "R2");
        set_pf(1);                                 check_all("R2 rise while disabled");
        set_pf(0);
    endtask

    task automatic t_pwrdn();
        bus_write(0, 0, 0, 32'h08, "R4");
        set_pf(1);                                 check_all("R4 fail set");
        bus_write(4, 0, 0, 32'hFD, "R4 FD");      check_all("R4 keep status");
        bus_write(4, 0, 0, 32'h02, "R5 clear");   check_all("R5 clear pf held");
        repeat (3) @(negedge clk);                 check_all("R5 no re-set");
        set_pf(0);
        set_pf(1);                                 check_all("R2 new rise");
        bus_write(4, 0, 0, 32'h03, "R5 03");      check_all("R5 off plus clear");
        bus_write(4, 0, 0, 32'h00, "R6 off");     check_all("R6 off cleared");
        set_pf(0);
    endtask

    task automatic t_sysctl();
        bus_write(5, 2, 0, 32'h0, "R7 no cmd");
        bus_write(5, 2, 0, 32'h1, "R7 cmd");      check_all("R7 cmd");
        bus_write(5, 2, 0, 32'hFFFF_FFFE, "R7 bit0 clear"); check_all("R7 bit0 clear");
    endtask

    task automatic t_size_offset();
        bus_write(0, 1, 0, 32'h77, "R9 cfg half");  check_all("R9 cfg half ignored");
        bus_write(1, 3, 0, 32'h11, "R9 diag rsvd"); check_all("R9 diag rsvd ignored");
        bus_write(3, 2, 0, 32'hFF, "R9 aux word");  check_all("R9 aux word ignored");
        read_chk(0, 2, 0, 0, "R9 cfg word read zero");
        read_chk(6, 2, 0, 0, "R9 led word read zero");
        bus_write(6, 1, 2, 32'h1234, "R10 led off2"); check_all("R10 led off2 ignored");
        read_chk(6, 1, 2, 0, "R10 led off2 read zero");
        read_chk(5, 2, 1, 0, "R10 sys off1 read zero");
        bus_write(6, 0, 0, 32'h4321, "R9 led byte"); check_all("R9 led byte ignored");
        bus_write(5, 1, 0, 32'h1, "R9 sys half"); check_all("R9 sys half ignored");
        bus_write(5, 2, 3, 32'h1, "R10 sys off3"); check_all("R10 sys off3 ignored");
    endtask

    task automatic t_same_cycle();
        bus_write(0, 0, 0, 32'h08, "R12");
        @(negedge clk);
        pf_in = 1; bus_cs = 7'h10; bus_wr = 1; bus_size = 0; bus_wdata = 32'h02;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0; bus_wdata = 0;
        m_pf = 1; m_fail = 0; m_off = 0;
        check_all("R12 clear wins over rise");
        repeat (2) @(negedge clk);
        check_all("R12 held input no re-set");
        set_pf(0);
        @(negedge clk);
        pf_in = 1; bus_cs = 7'h10; bus_wr = 1; bus_size = 0; bus_wdata = 32'h01;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0; bus_wdata = 0;
        m_pf = 1; m_fail = 1; m_off = 1;
        check_all("R12 rise with plain write");
    endtask

    task automatic t_reset_keep();
        bus_write(0, 0, 0, 32'h08, "R8");
        bus_write(2, 0, 0, 32'h3C, "R8");
        bus_write(3, 0, 0, 32'hF1, "R8");
        bus_write(4, 0, 0, 32'h01, "R8");
        bus_write(1, 0, 0, 32'hC3, "R8");
        bus_write(6, 1, 0, 32'h0F0F, "R8");
        check_all("R8 before reset");
        do_reset();
        check_all("R8 after reset kept and cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_plain_rw();
        t_aux_tc();
        t_power_fail();
        t_pwrdn();
        t_sysctl();
        t_size_offset();
        t_same_cycle();
        t_reset_keep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule